// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog counter driven by a slow tick strobe and governed by a single 32-bit control word. A write to the control word carries a reload count, a run/stop command bit and a 7-bit key. Once the stored word has its command bit set, the watchdog is armed. From then on, a write only takes effect if its key is the bitwise inverse of the key already stored. This means software has to alternate between a key and its complement each time it services the watchdog.

Each accepted write with the command bit set reloads the counter and lets it run. It counts down one step every `TICK_DIV` tick strobes. When the count runs out for the first time, the block raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before any accepted write, the block issues a one-cycle system reset request. The stored word, the live count, the expiry stage and the run state can all be read directly as outputs. Distributing the reset request to the rest of the chip is left to the surrounding logic.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `ctrlRead` is 0, `countRead` is 0, `running`, `nmi` and `resetReq` are 0, and `hitsRead` is 0.
- R2: In the control word, bits [7:0] are the reload count, bit 8 is the run command (it is also the armed flag once stored), and bits [15:9] are the key. An accepted write stores the whole 32-bit word, and it appears on `ctrlRead` one cycle later.
- R3: While stored bit 8 is 1, a write whose bits [15:9] differ from the 7-bit inverse of stored bits [15:9] is ignored. The stored word, count, run state, `nmi` and `hitsRead` stay as they were.
- R4: While stored bit 8 is 0, a write is accepted whatever its key.
- R5: An accepted write loads the counter from bits [7:0]. The counter runs if bit 8 is 1 and holds if bit 8 is 0.
- R6: A reload count of 0 loads 256.
- R7: While running, the count drops by one for every `TICK_DIV` tick strobes, and the strobe phase restarts on each accepted write. Tick strobes have no effect while the counter is stopped.
- R8: The first expiry happens on the tick step that would take the count from 1 to 0. At that point `nmi` goes to 1, the count reloads to `GRACE`, `hitsRead` becomes 1 and the counter keeps running.
- R9: If the grace count expires as well, `resetReq` is 1 for exactly one cycle, `hitsRead` becomes 2 and stays at 2, the counter stops, and `nmi` stays high.
- R10: An accepted write clears `nmi` and sets `hitsRead` to 0.
- R11: When an accepted write and a tick step that would expire fall in the same cycle, the write wins. The count takes the written value and no expiry is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickStrobe | input | 1 | Slow tick pulse, one cycle wide |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word to write |
| ctrlRead | output | 32 | Stored control word |
| countRead | output | 9 | Live counter value |
| hitsRead | output | 2 | Expiry stage (0, 1 or 2) |
| running | output | 1 | Counter is running |
| nmi | output | 1 | Non-maskable interrupt after first expiry |
| resetReq | output | 1 | One-cycle system reset request after second expiry |

## Verification
A wrong key comparison shows up in `ctrlRead` one cycle after the offending write. The word either changes when it should have stayed, or it stays when it should have changed. A fault in the counter or prescaler shows up as an expiry that comes early or late: `nmi` rises on a different tick step than expected, usually within a few ticks of the reload. Wrong expiry-stage tracking shows up as a `resetReq` pulse without a prior `nmi`, a pulse longer than one cycle, or `hitsRead` leaving the range 0 to 2. A reference model in the bench is stepped once per cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int CTRL_W  = 32;
  localparam int CNT_LSB = 0;
  localparam int CNT_W   = 8;
  localparam int CMD_BIT = 8;
  localparam int KEY_LSB = 9;
  localparam int KEY_W   = 7;
  localparam int LIVE_W  = CNT_W + 1;   // holds 256
  localparam int HIT_W   = 2;

  typedef struct packed {
    logic accept;     // take write: store word, reload, restart phase
    logic graceLoad;  // first expiry: reload grace count
    logic halt;       // second expiry: stop counter
  } wdStrobes_t;
endpackage

// File: rtl/kwd_control.sv
module kwd_control
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic [CTRL_W-1:0] storedCtrl,
  input  logic              expire,
  output wdStrobes_t        strobes,
  output logic              nmi,
  output logic              resetReq,
  output logic [HIT_W-1:0]  hits
);
  logic [KEY_W-1:0] expectKey;
  logic             armed;
  logic             keyOk;

  assign armed     = storedCtrl[CMD_BIT];
  assign expectKey = ~storedCtrl[KEY_LSB +: KEY_W];
  assign keyOk     = (wrData[KEY_LSB +: KEY_W] == expectKey);

  always_comb begin
    strobes = '0;
    strobes.accept = wrEn && (!armed || keyOk);
    if (!strobes.accept && expire) begin
      if (hits == HIT_W'(0)) strobes.graceLoad = 1'b1;
      else                   strobes.halt      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmi      <= 1'b0;
      resetReq <= 1'b0;
      hits     <= '0;
    end else begin
      resetReq <= 1'b0;
      if (strobes.accept) begin
        nmi  <= 1'b0;
        hits <= '0;
      end else if (strobes.graceLoad) begin
        nmi  <= 1'b1;
        hits <= HIT_W'(1);
      end else if (strobes.halt) begin
        resetReq <= 1'b1;
        hits     <= HIT_W'(2);
      end
    end
  end
endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int TICK_DIV = 1,
  parameter int GRACE    = 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStrobe,
  input  logic [CTRL_W-1:0] wrData,
  input  wdStrobes_t        strobes,
  output logic [CTRL_W-1:0] storedCtrl,
  output logic [LIVE_W-1:0] count,
  output logic              running,
  output logic              expire
);
  localparam int PRESC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [LIVE_W-1:0] FULL_LOAD  = LIVE_W'(1) << CNT_W;
  localparam logic [LIVE_W-1:0] GRACE_LOAD = LIVE_W'(GRACE);

  logic              tickFire;
  logic [LIVE_W-1:0] loadValue;

  generate
    if (TICK_DIV > 1) begin : g_presc
      logic [PRESC_W-1:0] phase;
      logic               wrap;
      assign wrap     = (phase == PRESC_W'(TICK_DIV - 1));
      assign tickFire = tickStrobe && running && wrap;
      always_ff @(posedge clk) begin
        if (!rstN || strobes.accept) phase <= '0;
        else if (tickStrobe && running) phase <= wrap ? '0 : phase + PRESC_W'(1);
      end
    end else begin : g_direct
      assign tickFire = tickStrobe && running;
    end
  endgenerate

  assign loadValue = (wrData[CNT_LSB +: CNT_W] == '0) ? FULL_LOAD
                     : {1'b0, wrData[CNT_LSB +: CNT_W]};
  assign expire    = tickFire && (count == LIVE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedCtrl <= '0;
      count      <= '0;
      running    <= 1'b0;
    end else if (strobes.accept) begin
      storedCtrl <= wrData;
      count      <= loadValue;
      running    <= wrData[CMD_BIT];
    end else if (strobes.graceLoad) begin
      count <= GRACE_LOAD;
    end else if (strobes.halt) begin
      count   <= '0;
      running <= 1'b0;
    end else if (tickFire) begin
      count <= count - LIVE_W'(1);
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int TICK_DIV = 1,
  parameter int GRACE    = 1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickStrobe,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] ctrlRead,
  output logic [8:0]  countRead,
  output logic [1:0]  hitsRead,
  output logic        running,
  output logic        nmi,
  output logic        resetReq
);
  wdStrobes_t strobes;
  logic       expire;

  kwd_control u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .storedCtrl(ctrlRead), .expire(expire), .strobes(strobes),
    .nmi(nmi), .resetReq(resetReq), .hits(hitsRead)
  );

  kwd_datapath #(.TICK_DIV(TICK_DIV), .GRACE(GRACE)) u_datapath (
    .clk(clk), .rstN(rstN), .tickStrobe(tickStrobe), .wrData(wrData),
    .strobes(strobes), .storedCtrl(ctrlRead), .count(countRead),
    .running(running), .expire(expire)
  );
endmodule

// File: rtl/keyed_watchdog_checker.sv
module keyed_watchdog_checker #(
  parameter int GRACE = 1
)(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] ctrlRead,
  input logic [8:0]  countRead,
  input logic [1:0]  hitsRead,
  input logic        running,
  input logic        nmi,
  input logic        resetReq
);
  logic badKey;
  assign badKey = ctrlRead[8] && (wrData[15:9] != ~ctrlRead[15:9]);

  initial assert (GRACE >= 1) else $error("GRACE must be at least 1");

  p_rejected_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && badKey) |=> $stable(ctrlRead));

  p_accept_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !badKey) |=> (!nmi && hitsRead == 2'd0));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  p_reset_after_nmi_r9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (nmi && hitsRead == 2'd2 && !running));

  p_nmi_grace_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmi) |-> (hitsRead == 2'd1 && countRead == 9'(GRACE) && running));

  p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !wrEn) |=> $stable(countRead));

  p_hits_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    hitsRead != 2'd3);
endmodule

bind keyed_watchdog keyed_watchdog_checker #(.GRACE(GRACE)) u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .ctrlRead(ctrlRead), .countRead(countRead), .hitsRead(hitsRead),
  .running(running), .nmi(nmi), .resetReq(resetReq)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 2;
  localparam int GR = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickStrobe = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] ctrlRead;
  logic [8:0]  countRead;
  logic [1:0]  hitsRead;
  logic        running, nmi, resetReq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] mCtrl;
  int mCount, mHits, mPhase;
  bit mRun, mNmi, mRst;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog #(.TICK_DIV(TD), .GRACE(GR)) uut (
    .clk(clk), .rstN(rstN), .tickStrobe(tickStrobe), .wrEn(wrEn),
    .wrData(wrData), .ctrlRead(ctrlRead), .countRead(countRead),
    .hitsRead(hitsRead), .running(running), .nmi(nmi), .resetReq(resetReq)
  );

  function automatic logic [31:0] word(input int key, input bit cmd, input int cnt);
    return (32'(key & 7'h7f) << 9) | (32'(cmd) << 8) | 32'(cnt & 8'hff);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mCtrl = '0; mCount = 0; mHits = 0; mPhase = 0;
    mRun = 0; mNmi = 0; mRst = 0;
  endtask

  task automatic modelStep(input bit wr, input logic [31:0] d, input bit tk);
    bit accept;
    accept = wr && (!mCtrl[8] || d[15:9] == ~mCtrl[15:9]);
    mRst = 0;
    if (accept) begin
      mCtrl = d;
      mCount = (d[7:0] == 0) ? 256 : int'(d[7:0]);
      mRun = d[8]; mPhase = 0; mHits = 0; mNmi = 0;
    end else if (tk && mRun) begin
      if (mPhase == TD - 1) begin
        mPhase = 0;
        if (mCount == 1) begin
          if (mHits == 0) begin
            mNmi = 1; mHits = 1; mCount = GR;
          end else begin
            mRst = 1; mHits = 2; mRun = 0; mCount = 0;
          end
        end else mCount--;
      end else mPhase++;
    end
  endtask

  task automatic compareAll();
    check("R2 ctrlRead", int'(ctrlRead), int'(mCtrl));
    check("R7 countRead", int'(countRead), mCount);
    check("R5 running", int'(running), int'(mRun));
    check("R8 nmi", int'(nmi), int'(mNmi));
    check("R9 resetReq", int'(resetReq), int'(mRst));
    check("R10 hitsRead", int'(hitsRead), mHits);
  endtask

  // one cycle: drive after negedge, sample at the following negedge
  task automatic step(input bit wr, input logic [31:0] d, input bit tk);
    wrEn = wr; wrData = d; tickStrobe = tk;
    @(posedge clk);
    modelStep(wr, d, tk);
    @(negedge clk);
    wrEn = 0; tickStrobe = 0;
    compareAll();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int key;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 ctrl", int'(ctrlRead), 0);
    check("R1 count", int'(countRead), 0);
    check("R1 flags", int'({running, nmi, resetReq}), 0);
    check("R1 hits", int'(hitsRead), 0);

    // R2/R5 arm with key 15, count 3
    step(1, word(7'h15, 1, 3), 0);
    check("R2 stored word", int'(ctrlRead), int'(word(7'h15, 1, 3)));
    check("R5 runs", int'(running), 1);
    // R3 same key again: rejected
    step(1, word(7'h15, 1, 9), 0);
    check("R3 word kept", int'(ctrlRead), int'(word(7'h15, 1, 3)));
    check("R3 count kept", int'(countRead), 3);
    // R7 stopped-free ticks: 2 strobes per step
    step(0, '0, 1); step(0, '0, 1);
    check("R7 one step", int'(countRead), 2);
    repeat (4) step(0, '0, 1);
    check("R8 nmi", int'(nmi), 1);
    check("R8 grace", int'(countRead), GR);
    check("R8 hits", int'(hitsRead), 1);
    step(0, '0, 1); step(0, '0, 1);
    check("R9 pulse", int'(resetReq), 1);
    step(0, '0, 1);
    check("R9 pulse ends", int'(resetReq), 0);
    check("R9 nmi held", int'(nmi), 1);
    check("R9 hits sat", int'(hitsRead), 2);
    // R10/R6 serviced with inverted key, count 0, stop
    step(1, word(7'h6a, 0, 0), 0);
    check("R10 nmi cleared", int'(nmi), 0);
    check("R10 hits cleared", int'(hitsRead), 0);
    check("R6 count 256", int'(countRead), 256);
    step(0, '0, 1); step(0, '0, 1);
    check("R7 stopped holds", int'(countRead), 256);
    // R4 disarmed: any key
    step(1, word(7'h00, 1, 1), 0);
    check("R4 accepted", int'(ctrlRead), int'(word(7'h00, 1, 1)));
    step(0, '0, 1);
    // R11 next tick would expire; write wins
    step(1, word(7'h7f, 1, 5), 1);
    check("R11 write wins count", int'(countRead), 5);
    check("R11 no expiry", int'(nmi), 0);

    // constrained random
    void'($urandom(32'h5eed));
    key = 0;
    for (int i = 0; i < 4000; i++) begin
      bit wr, tk;
      logic [31:0] d;
      int cnt;
      wr = ($urandom % 12) == 0;
      tk = ($urandom % 2) == 0;
      cnt = ($urandom % 4 == 0) ? 0 : int'($urandom % 6);
      if ($urandom % 3 != 0) key = int'(~mCtrl[15:9]);
      else key = int'($urandom % 128);
      d = word(key, ($urandom % 5) != 0, cnt) | (32'($urandom) & 32'hffff0000);
      step(wr, d, tk);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule